// File: doc/BRIEF.md
# Coupling-Aware Flit Link Codec

This block sits on one network-on-chip link and cuts the switching and coupling activity of the wires. It has an encoder on the sending side and a decoder on the receiving side. For each body flit, the encoder compares the payload with the word last driven on the link. It works out the adjacent-pair transition cost of sending the payload unchanged and of sending one inverted form, then drives the cheaper of the two. One extra wire tells the decoder whether the word was inverted. The decoder rebuilds the original payload from that wire, the received word and the word it received before.

A single flag bit cannot say which of two inversions was used. The choice between flipping only the odd-indexed lines and flipping every line is therefore made by a majority vote over the odd lines. Odd inversion and full inversion leave the same values on the odd lines, so the decoder can repeat that vote on what it receives. Both sides keep a register holding the previous link word, cleared to zero at reset. Head flits are never encoded. The input handshake passes straight through to the link, and the decoder side has no backpressure.

Top module: `coupling_link_codec`

## Requirements
- R1: The link word is W+1 bits wide. Bits W-1..0 carry the payload and bit W is the invert flag. The head flag travels on `link_head_o`. `link_valid_o` follows `in_valid_i`, and `in_ready_o` follows `link_ready_i`, in the same cycle.
- R2: A head flit is driven with its payload unchanged and the invert flag at 0, whatever the cost.
- R3: The cost of a word against the previous link word is the number of lines that toggle, plus a weight for each adjacent pair (i, i+1). The weight is 1 when exactly one line of the pair toggles, 2 when both toggle to different final values, and 0 when both toggle to the same value or neither toggles. A body flit is sent inverted, with the flag at 1, only when the inverted form costs strictly less than the plain form. A tie keeps the plain form.
- R4: The inverted form of payload x is ~x when more than half of the odd-indexed lines of ~x differ from the previous link word. Otherwise it is x with bits 1, 3, 5, ... flipped. Both forms occur in use.
- R5: The encoder's previous-word register is all zeros after reset. It takes the driven payload on every accepted flit (valid and ready, head flits included) and holds while the link stalls.
- R6: The decoder returns the original payload bit for bit. With the flag at 0 or on a head flit, it returns the received bits as they are. With the flag at 1, it repeats the odd-line majority vote against its own previous word and undoes full or odd inversion to match.
- R7: The decoder's previous-word register is all zeros after reset and takes the received payload on every cycle with `rx_valid_i` high.
- R8: `out_valid_o` and `out_head_o` follow `rx_valid_i` and `rx_head_i` in the same cycle.
- R9: The cost of the driven payload never exceeds the cost of the plain payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Flit offered to the encoder |
| in_ready_o | output | 1 | Encoder accepts the flit |
| in_head_i | input | 1 | Offered flit is a head flit |
| in_data_i | input | W | Offered payload |
| link_valid_o | output | 1 | Link word valid |
| link_ready_i | input | 1 | Link accepts the word |
| link_head_o | output | 1 | Head flag on the link |
| link_word_o | output | W+1 | Encoded payload with the invert flag in bit W |
| rx_valid_i | input | 1 | Received link word valid |
| rx_head_i | input | 1 | Received head flag |
| rx_word_i | input | W+1 | Received encoded word |
| out_valid_o | output | 1 | Decoded flit valid |
| out_head_o | output | 1 | Decoded head flag |
| out_data_o | output | W | Decoded payload |

## Verification
The properties assume that the decoder sees exactly the flits the encoder had accepted, in the same order, with nothing dropped or repeated. Only under that assumption do the two previous-word registers agree, and only then can the inverted-flag decode be judged. The bench keeps to this by looping the link outputs back into the receive side and raising `rx_valid_i` only when the link is both valid and ready. Stalls therefore reach neither register. The stimulus mixes random words, counting and single-bit-step sequences, alternating line patterns, head flits at random points, and runs of stalled cycles.

// File: rtl/link_codec_pkg.sv
package link_codec_pkg;

  typedef enum logic [1:0] {
    PAIR_IDLE     = 2'd0,
    PAIR_LONE     = 2'd1,
    PAIR_PARALLEL = 2'd2,
    PAIR_OPPOSED  = 2'd3
  } pair_kind_e;

  function automatic logic [1:0] pair_weight(pair_kind_e kind);
    case (kind)
      PAIR_LONE:    return 2'd1;
      PAIR_OPPOSED: return 2'd2;
      default:      return 2'd0;
    endcase
  endfunction

  function automatic int cost_width(int w);
    return $clog2(3 * w);
  endfunction

endpackage

// File: rtl/pair_classifier.sv
module pair_classifier
  import link_codec_pkg::*;
(
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  output logic [1:0] weight_o
);
  logic [1:0] tog;
  pair_kind_e kind;

  assign tog = cur_i ^ prev_i;

  always_comb begin
    case (tog)
      2'b00:   kind = PAIR_IDLE;
      2'b11:   kind = (cur_i[0] == cur_i[1]) ? PAIR_PARALLEL : PAIR_OPPOSED;
      default: kind = PAIR_LONE;
    endcase
  end

  assign weight_o = pair_weight(kind);
endmodule

// File: rtl/link_cost.sv
module link_cost #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic [W-1:0]  cur_i,
  input  logic [W-1:0]  prev_i,
  output logic [CW-1:0] cost_o
);
  localparam int NPAIR = W - 1;

  logic [1:0] pair_w [NPAIR];

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    pair_classifier u_cls (
      .cur_i   (cur_i[g+1:g]),
      .prev_i  (prev_i[g+1:g]),
      .weight_o(pair_w[g])
    );
  end

  always_comb begin
    cost_o = '0;
    for (int i = 0; i < W; i++) cost_o = cost_o + CW'(cur_i[i] ^ prev_i[i]);
    for (int i = 0; i < NPAIR; i++) cost_o = cost_o + CW'(pair_w[i]);
  end
endmodule

// File: rtl/odd_majority.sv
module odd_majority #(
  parameter int W = 16
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] prev_i,
  output logic         full_o
);
  localparam int NODD = W / 2;

  int cnt;

  always_comb begin
    cnt = 0;
    for (int i = 1; i < W; i += 2) cnt = cnt + int'(word_i[i] ^ prev_i[i]);
    full_o = (2 * cnt) > NODD;
  end
endmodule

// File: rtl/link_encoder.sv
module link_encoder #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         ready_i,
  input  logic         head_i,
  input  logic [W-1:0] data_i,
  output logic [W:0]   word_o,
  output logic [W-1:0] prev_o
);
  function automatic logic [W-1:0] odd_mask_f();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD_MASK = odd_mask_f();

  logic [W-1:0]  prev_q;
  logic [W-1:0]  all_inv;
  logic [W-1:0]  cand;
  logic          full_sel;
  logic [CW-1:0] cost_plain;
  logic [CW-1:0] cost_cand;
  logic          use_inv;

  assign all_inv = ~data_i;

  // odd lines are equal under both inversions, so the decoder can repeat this vote
  odd_majority #(.W(W)) u_vote (
    .word_i(all_inv),
    .prev_i(prev_q),
    .full_o(full_sel)
  );

  assign cand = full_sel ? all_inv : (data_i ^ ODD_MASK);

  link_cost #(.W(W), .CW(CW)) u_cost_plain (
    .cur_i (data_i),
    .prev_i(prev_q),
    .cost_o(cost_plain)
  );

  link_cost #(.W(W), .CW(CW)) u_cost_cand (
    .cur_i (cand),
    .prev_i(prev_q),
    .cost_o(cost_cand)
  );

  assign use_inv = !head_i && (cost_cand < cost_plain);
  assign word_o  = use_inv ? {1'b1, cand} : {1'b0, data_i};
  assign prev_o  = prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prev_q <= '0;
    else if (valid_i && ready_i) prev_q <= word_o[W-1:0];
  end
endmodule

// File: rtl/link_decoder.sv
module link_decoder #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         head_i,
  input  logic [W:0]   word_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] prev_o
);
  function automatic logic [W-1:0] odd_mask_f();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD_MASK = odd_mask_f();

  logic [W-1:0] prev_q;
  logic [W-1:0] pay;
  logic         full_sel;

  assign pay = word_i[W-1:0];

  odd_majority #(.W(W)) u_vote (
    .word_i(pay),
    .prev_i(prev_q),
    .full_o(full_sel)
  );

  always_comb begin
    if (head_i || !word_i[W]) data_o = pay;
    else if (full_sel)        data_o = ~pay;
    else                      data_o = pay ^ ODD_MASK;
  end

  assign prev_o = prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (valid_i) prev_q <= pay;
  end
endmodule

// File: rtl/coupling_link_codec.sv
module coupling_link_codec #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic         in_head_i,
  input  logic [W-1:0] in_data_i,
  output logic         link_valid_o,
  input  logic         link_ready_i,
  output logic         link_head_o,
  output logic [W:0]   link_word_o,
  input  logic         rx_valid_i,
  input  logic         rx_head_i,
  input  logic [W:0]   rx_word_i,
  output logic         out_valid_o,
  output logic         out_head_o,
  output logic [W-1:0] out_data_o
);
  localparam int CW = link_codec_pkg::cost_width(W);

  logic [W-1:0] enc_prev;
  logic [W-1:0] dec_prev;

  assign in_ready_o   = link_ready_i;
  assign link_valid_o = in_valid_i;
  assign link_head_o  = in_head_i;

  link_encoder #(.W(W), .CW(CW)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .ready_i(link_ready_i),
    .head_i (in_head_i),
    .data_i (in_data_i),
    .word_o (link_word_o),
    .prev_o (enc_prev)
  );

  link_decoder #(.W(W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .head_i (rx_head_i),
    .word_i (rx_word_i),
    .data_o (out_data_o),
    .prev_o (dec_prev)
  );

  assign out_valid_o = rx_valid_i;
  assign out_head_o  = rx_head_i;
endmodule

// File: rtl/coupling_link_codec_chk.sv
module coupling_link_codec_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         in_head_i,
  input logic [W-1:0] in_data_i,
  input logic [W:0]   link_word_o,
  input logic         rx_valid_i,
  input logic [W:0]   rx_word_i,
  input logic [W-1:0] out_data_o,
  input logic [W-1:0] enc_prev,
  input logic [W-1:0] dec_prev
);
  function automatic logic [W-1:0] odd_mask_f();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD_MASK = odd_mask_f();

  assert_head_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_head_i |-> link_word_o == {1'b0, in_data_i});

  assert_inv_form_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && link_word_o[W] |->
      (link_word_o[W-1:0] == ~in_data_i) || (link_word_o[W-1:0] == (in_data_i ^ ODD_MASK)));

  assert_enc_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && in_ready_o) |-> enc_prev == $past(link_word_o[W-1:0]));

  assert_enc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_valid_i && in_ready_o) |-> $stable(enc_prev));

  assert_dec_plain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !rx_word_i[W] |-> out_data_o == rx_word_i[W-1:0]);

  assert_dec_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_valid_i) |-> dec_prev == $past(rx_word_i[W-1:0]));
endmodule

bind coupling_link_codec coupling_link_codec_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_head_i  (in_head_i),
  .in_data_i  (in_data_i),
  .link_word_o(link_word_o),
  .rx_valid_i (rx_valid_i),
  .rx_word_i  (rx_word_i),
  .out_data_o (out_data_o),
  .enc_prev   (enc_prev),
  .dec_prev   (dec_prev)
);

// File: tb/coupling_link_codec_tb_top.sv
module coupling_link_codec_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_head = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         link_valid;
  logic         link_ready = 1'b0;
  logic         link_head;
  logic [W:0]   link_word;
  logic         rx_valid;
  logic         out_valid;
  logic         out_head;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int n_full = 0;
  int n_odd = 0;
  logic [W-1:0] m_prev = '0;

  always #4 clk = ~clk;

  assign rx_valid = link_valid && link_ready;

  coupling_link_codec #(.W(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_head_i   (in_head),
    .in_data_i   (in_data),
    .link_valid_o(link_valid),
    .link_ready_i(link_ready),
    .link_head_o (link_head),
    .link_word_o (link_word),
    .rx_valid_i  (rx_valid),
    .rx_head_i   (link_head),
    .rx_word_i   (link_word),
    .out_valid_o (out_valid),
    .out_head_o  (out_head),
    .out_data_o  (out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_cost(logic [W-1:0] cur, logic [W-1:0] prv);
    int c = 0;
    for (int i = 0; i < W; i++) if (cur[i] != prv[i]) c++;
    for (int i = 0; i < W - 1; i++) begin
      bit a = cur[i] != prv[i];
      bit b = cur[i+1] != prv[i+1];
      if (a != b) c += 1;
      else if (a && cur[i] != cur[i+1]) c += 2;
    end
    return c;
  endfunction

  function automatic logic [W:0] ref_encode(bit head, logic [W-1:0] x, logic [W-1:0] prv, output bit full);
    logic [W-1:0] cand;
    int ones = 0;
    full = 1'b0;
    if (head) return {1'b0, x};
    for (int i = 1; i < W; i += 2) if ((~x[i]) != prv[i]) ones++;
    full = (2 * ones) > (W / 2);
    cand = x;
    for (int i = 0; i < W; i++) if (full || (i % 2) == 1) cand[i] = ~x[i];
    if (ref_cost(cand, prv) < ref_cost(x, prv)) return {1'b1, cand};
    return {1'b0, x};
  endfunction

  task automatic send(input bit head, input logic [W-1:0] x, input bit rdy);
    logic [W:0] exp;
    bit full;
    @(negedge clk);
    in_valid = 1'b1;
    in_head = head;
    in_data = x;
    link_ready = rdy;
    #1;
    exp = ref_encode(head, x, m_prev, full);
    chk(link_word == exp, head ? "R2 head word" : "R3 R4 body word", 64'(link_word), 64'(exp));
    chk(link_valid && in_ready == rdy && link_head == head, "R1 handshake", {61'd0, link_valid, in_ready, link_head}, {61'd0, 1'b1, rdy, head});
    chk(ref_cost(link_word[W-1:0], m_prev) <= ref_cost(x, m_prev), "R9 cost bound",
        64'(ref_cost(link_word[W-1:0], m_prev)), 64'(ref_cost(x, m_prev)));
    if (rdy) begin
      chk(out_data == x, "R6 decoded data", 64'(out_data), 64'(x));
      chk(out_valid && out_head == head, "R8 out flags", {62'd0, out_valid, out_head}, {62'd0, 1'b1, head});
      if (!head && exp[W]) begin
        if (full) n_full++;
        else n_odd++;
      end
    end else begin
      chk(!out_valid, "R8 out idle on stall", 64'(out_valid), 64'd0);
    end
    @(posedge clk);
    if (rdy) m_prev = exp[W-1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk(!link_valid && !out_valid, "R1 R8 reset idle", {62'd0, link_valid, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b0, '0, 1'b1);               // R5 R7 registers start at zero
    send(1'b0, 16'h5555, 1'b1);
    send(1'b0, 16'hAAAA, 1'b1);
    send(1'b0, 16'h5555, 1'b1);
    send(1'b1, 16'hAAAA, 1'b1);         // R2 head never inverted
    send(1'b0, 16'hFFFF, 1'b1);
    send(1'b0, 16'h0000, 1'b1);
    // R5 stall: link words must track an unchanged previous word
    for (int i = 0; i < 6; i++) send(1'b0, 16'($urandom), 1'b0);
    send(1'b0, 16'h3C3C, 1'b1);
    for (int i = 0; i < 400; i++)
      send(($urandom % 8) == 0, 16'($urandom), ($urandom % 4) != 0);
    v = 16'h00F0;
    for (int i = 0; i < 200; i++) begin
      send(1'b0, v, 1'b1);
      v = v + 16'd1;
    end
    for (int i = 0; i < 200; i++) begin
      send(($urandom % 16) == 0, v, ($urandom % 5) != 0);
      v[$urandom % W] ^= 1'b1;
    end
    for (int i = 0; i < 100; i++)
      send(1'b0, (i % 2) ? 16'hAAAA ^ 16'($urandom % 4) : 16'h5555, 1'b1);
    chk(n_full > 0, "R4 full inversion seen", 64'(n_full), 64'd1);
    chk(n_odd > 0, "R4 odd inversion seen", 64'(n_odd), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule